// File: doc/BRIEF.md
# Audio capture ring-buffer writer

This block sits between an audio serial receiver and system memory. It accepts 32-bit sample words on a valid/ready stream and stores each one into a circular buffer in memory through a single-beat write request port. The buffer's base address and its size in bytes are set by software. The size is a power of two and can be up to 2 MiB. The block owns the producer index, which is the byte offset of the next slot it will fill. Software owns the consumer index, which marks how far it has read.

The producer stops one slot short of the consumer index, so the ring is never fully occupied. When the next write would land the producer on the consumer offset, the block stops taking samples. It resumes once software advances its index. A period counter groups written words into frames, using one word per channel. After a programmed number of frames it raises a pending bit. That bit lives in a small separate interrupt register space, where a mask gates it onto the interrupt line.

Top module: `cap_ring_writer`

## Requirements
- R1: After reset, the producer index reads 0, no memory write is requested, `smp_ready` is low and `irq_out` is low.
- R2: Each accepted sample word is written unchanged to address base + producer index. The producer index advances by 4 when memory accepts the write, and wraps modulo the buffer size.
- R3: The block takes no sample while (producer index + 4) mod size equals the consumer index. It resumes once the consumer index moves.
- R4: While `mw_valid` is high and `mw_ready` is low, `mw_valid`, `mw_addr` and `mw_data` hold their values.
- R5: With enable (offset 0x14, bit 0) cleared, no sample is accepted. A write already pending still completes and advances the producer index.
- R6: Writing 1 to bit 0 at offset 0x2C clears the producer index, the consumer index and the period counters, and withdraws a pending memory write.
- R7: Offset 0x4C holds the period length in frames in bits [31:8] and a period-interrupt enable in bit 0. Offset 0x30 bits [7:0] hold the channel count, where 0 acts as 1. A frame is one written word per channel. Each time the programmed number of frames has been written, the pending bit is set if bit 0 is 1. A period length of 0 never sets the pending bit.
- R8: In the interrupt space, offset 0xC reads the pending bit in bit 0. Writing 1 to bit 0 there clears it. A new period event in the same cycle wins over the clear.
- R9: `irq_out` is high exactly when the pending bit is set and bit 0 of the mask register (interrupt space, offset 0x8) is 1.
- R10: Base (0x18), size in bytes (0x1C), consumer index (0x24), enable, channel count and period settings read back what was written. Offset 0x20 returns the producer index and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_addr | input | 8 | Configuration register byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data (combinational on cfg_addr) |
| irq_we | input | 1 | Interrupt register write strobe |
| irq_addr | input | 4 | Interrupt register byte offset |
| irq_wdata | input | 32 | Interrupt register write data |
| irq_rdata | output | 32 | Interrupt register read data |
| irq_out | output | 1 | Masked period interrupt |
| smp_valid | input | 1 | Sample word offered |
| smp_data | input | 32 | Sample word |
| smp_ready | output | 1 | Sample word taken this cycle when valid |
| mw_valid | output | 1 | Memory write request |
| mw_addr | output | 32 | Memory write byte address |
| mw_data | output | 32 | Memory write data |
| mw_ready | input | 1 | Memory accepts the request |

## Verification
The bench uses a 32-byte ring of eight slots. It fills the ring until the producer stalls one slot before the consumer. A design that allowed a full ring would write an eighth word and overwrite unread data. It then moves the consumer index so that the producer wraps through offset 0, which catches address arithmetic that fails to mask the index or that computes the wrong slot.

Period counting is checked with two channels and three frames: the pending bit must stay clear after five words and be set after six. The bench also covers a channel count of 0, a cleared enable bit and repeated periods, which expose off-by-one frame counters. Further checks hold the memory port stalled while enable is cleared or a soft reset is written. These reveal a design that drops or duplicates the pending write, or that keeps the producer index after a soft reset.

// File: rtl/cap_ring_pkg.sv
package cap_ring_pkg;

    localparam int unsigned DW         = 32;
    localparam int unsigned AW         = 32;
    localparam int unsigned CFG_AW     = 8;
    localparam int unsigned IRQ_AW     = 4;
    localparam int unsigned CH_W       = 8;
    localparam int unsigned PER_LSB    = 8;
    localparam int unsigned PER_W      = DW - PER_LSB;
    localparam int unsigned WORD_BYTES = DW / 8;

    // configuration space byte offsets
    localparam logic [CFG_AW-1:0] OFS_ENABLE = 8'h14;
    localparam logic [CFG_AW-1:0] OFS_BASE   = 8'h18;
    localparam logic [CFG_AW-1:0] OFS_SIZE   = 8'h1C;
    localparam logic [CFG_AW-1:0] OFS_PROD   = 8'h20;
    localparam logic [CFG_AW-1:0] OFS_CONS   = 8'h24;
    localparam logic [CFG_AW-1:0] OFS_SRST   = 8'h2C;
    localparam logic [CFG_AW-1:0] OFS_CHAN   = 8'h30;
    localparam logic [CFG_AW-1:0] OFS_PERIOD = 8'h4C;

    // interrupt space byte offsets
    localparam logic [IRQ_AW-1:0] IOFS_MASK  = 4'h8;
    localparam logic [IRQ_AW-1:0] IOFS_STAT  = 4'hC;

    typedef struct packed {
        logic [CH_W-1:0]  chan;
        logic [PER_W-1:0] frames;
        logic             ie;
    } period_cfg_t;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } mwr_t;

    // next ring offset: one word further, folded by the size mask
    function automatic logic [AW-1:0] ring_step(input logic [AW-1:0] idx,
                                                input logic [AW-1:0] mask);
        return (idx + AW'(WORD_BYTES)) & mask;
    endfunction

endpackage

// File: rtl/cap_ring_regs.sv
module cap_ring_regs
    import cap_ring_pkg::*;
#(
    parameter int unsigned IDX_W = 21
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [DW-1:0]     cfg_wdata,
    input  logic [IDX_W-1:0]  prod_idx,
    output logic [DW-1:0]     cfg_rdata,
    output logic              en,
    output logic [AW-1:0]     base,
    output logic [IDX_W-1:0]  mask,
    output logic [IDX_W-1:0]  cons,
    output period_cfg_t       pcfg,
    output logic              srst
);

    localparam int unsigned SZ_W  = IDX_W + 1;
    localparam int unsigned SZ_PAD = DW - SZ_W;
    localparam int unsigned IX_PAD = DW - IDX_W;

    logic [SZ_W-1:0]  size_r;
    logic [CH_W-1:0]  chan_r;
    logic [PER_W-1:0] per_r;
    logic             ie_r;

    assign srst = cfg_we && (cfg_addr == OFS_SRST) && cfg_wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            en     <= 1'b0;
            base   <= '0;
            size_r <= '0;
            cons   <= '0;
            chan_r <= '0;
            per_r  <= '0;
            ie_r   <= 1'b0;
        end else begin
            if (srst) begin
                cons <= '0;
            end
            if (cfg_we) begin
                case (cfg_addr)
                    OFS_ENABLE: en     <= cfg_wdata[0];
                    OFS_BASE:   base   <= cfg_wdata;
                    OFS_SIZE:   size_r <= cfg_wdata[SZ_W-1:0];
                    OFS_CONS:   cons   <= {cfg_wdata[IDX_W-1:2], 2'b00};
                    OFS_CHAN:   chan_r <= cfg_wdata[CH_W-1:0];
                    OFS_PERIOD: begin
                        per_r <= cfg_wdata[DW-1:PER_LSB];
                        ie_r  <= cfg_wdata[0];
                    end
                    default: ;
                endcase
            end
        end
    end

    // power-of-two size: low bits minus one give the wrap mask
    assign mask = size_r[IDX_W-1:0] - 1'b1;

    assign pcfg.chan   = chan_r;
    assign pcfg.frames = per_r;
    assign pcfg.ie     = ie_r;

    always_comb begin
        case (cfg_addr)
            OFS_ENABLE: cfg_rdata = {{(DW-1){1'b0}}, en};
            OFS_BASE:   cfg_rdata = base;
            OFS_SIZE:   cfg_rdata = {{SZ_PAD{1'b0}}, size_r};
            OFS_PROD:   cfg_rdata = {{IX_PAD{1'b0}}, prod_idx};
            OFS_CONS:   cfg_rdata = {{IX_PAD{1'b0}}, cons};
            OFS_CHAN:   cfg_rdata = {{(DW-CH_W){1'b0}}, chan_r};
            OFS_PERIOD: cfg_rdata = {per_r, {(PER_LSB-1){1'b0}}, ie_r};
            default:    cfg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/cap_ring_ptr.sv
module cap_ring_ptr
    import cap_ring_pkg::*;
#(
    parameter int unsigned IDX_W = 21
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             srst,
    input  logic             en,
    input  logic [AW-1:0]    base,
    input  logic [IDX_W-1:0] mask,
    input  logic [IDX_W-1:0] cons,
    input  logic             smp_valid,
    input  logic [DW-1:0]    smp_data,
    output logic             smp_ready,
    output logic             mw_valid,
    output mwr_t             mw_req,
    input  logic             mw_ready,
    output logic [IDX_W-1:0] prod_idx,
    output logic             wr_done
);

    localparam int unsigned PAD = AW - IDX_W;

    logic [AW-1:0]    step_full;
    logic [IDX_W-1:0] prod_next;
    logic             ring_full;

    assign step_full = ring_step({{PAD{1'b0}}, prod_idx}, {{PAD{1'b0}}, mask});
    assign prod_next = step_full[IDX_W-1:0];
    assign ring_full = (prod_next == cons);

    // one request in flight; a new word only when the port is idle
    assign smp_ready = en && !mw_valid && !ring_full;
    assign wr_done   = mw_valid && mw_ready;

    always_ff @(posedge clk) begin
        if (rst || srst) begin
            mw_valid <= 1'b0;
            mw_req   <= '0;
            prod_idx <= '0;
        end else if (wr_done) begin
            mw_valid <= 1'b0;
            prod_idx <= prod_next;
        end else if (smp_valid && smp_ready) begin
            mw_valid    <= 1'b1;
            mw_req.addr <= base + {{PAD{1'b0}}, prod_idx};
            mw_req.data <= smp_data;
        end
    end

endmodule

// File: rtl/cap_ring_period.sv
module cap_ring_period
    import cap_ring_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              srst,
    input  logic              wr_done,
    input  period_cfg_t       pcfg,
    input  logic              irq_we,
    input  logic [IRQ_AW-1:0] irq_addr,
    input  logic [DW-1:0]     irq_wdata,
    output logic [DW-1:0]     irq_rdata,
    output logic              irq_out
);

    logic [CH_W-1:0]  word_cnt;
    logic [PER_W-1:0] frame_cnt;
    logic [CH_W-1:0]  chan_eff;
    logic             last_word;
    logic             last_frame;
    logic             frame_done;
    logic             period_hit;
    logic             pend;
    logic             pend_set;
    logic             pend_clr;
    logic [DW-1:0]    mask_r;

    assign chan_eff   = (pcfg.chan == '0) ? CH_W'(1) : pcfg.chan;
    assign last_word  = (word_cnt >= chan_eff - 1'b1);
    assign last_frame = (frame_cnt >= pcfg.frames - 1'b1);
    assign frame_done = wr_done && last_word;
    assign period_hit = frame_done && (pcfg.frames != '0) && last_frame;

    assign pend_set = period_hit && pcfg.ie;
    assign pend_clr = irq_we && (irq_addr == IOFS_STAT) && irq_wdata[0];

    always_ff @(posedge clk) begin
        if (rst || srst) begin
            word_cnt  <= '0;
            frame_cnt <= '0;
        end else if (wr_done) begin
            word_cnt <= last_word ? '0 : word_cnt + 1'b1;
            if (frame_done) begin
                frame_cnt <= period_hit ? '0 : frame_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend   <= 1'b0;
            mask_r <= '0;
        end else begin
            pend <= (pend && !pend_clr) || pend_set;
            if (irq_we && (irq_addr == IOFS_MASK)) begin
                mask_r <= irq_wdata;
            end
        end
    end

    assign irq_out = pend && mask_r[0];

    always_comb begin
        case (irq_addr)
            IOFS_MASK: irq_rdata = mask_r;
            IOFS_STAT: irq_rdata = {{(DW-1){1'b0}}, pend};
            default:   irq_rdata = '0;
        endcase
    end

endmodule

// File: rtl/cap_ring_writer.sv
module cap_ring_writer
    import cap_ring_pkg::*;
#(
    parameter int unsigned IDX_W = 21
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [DW-1:0]     cfg_wdata,
    output logic [DW-1:0]     cfg_rdata,
    input  logic              irq_we,
    input  logic [IRQ_AW-1:0] irq_addr,
    input  logic [DW-1:0]     irq_wdata,
    output logic [DW-1:0]     irq_rdata,
    output logic              irq_out,
    input  logic              smp_valid,
    input  logic [DW-1:0]     smp_data,
    output logic              smp_ready,
    output logic              mw_valid,
    output logic [AW-1:0]     mw_addr,
    output logic [DW-1:0]     mw_data,
    input  logic              mw_ready
);

    logic             cfg_en;
    logic [AW-1:0]    base_addr;
    logic [IDX_W-1:0] idx_mask;
    logic [IDX_W-1:0] cons_idx;
    logic [IDX_W-1:0] prod_idx;
    logic             srst_w;
    logic             wr_done;
    period_cfg_t      pcfg;
    mwr_t             mw_req;

    cap_ring_regs #(.IDX_W(IDX_W)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .prod_idx  (prod_idx),
        .cfg_rdata (cfg_rdata),
        .en        (cfg_en),
        .base      (base_addr),
        .mask      (idx_mask),
        .cons      (cons_idx),
        .pcfg      (pcfg),
        .srst      (srst_w)
    );

    cap_ring_ptr #(.IDX_W(IDX_W)) ptr_i (
        .clk       (clk),
        .rst       (rst),
        .srst      (srst_w),
        .en        (cfg_en),
        .base      (base_addr),
        .mask      (idx_mask),
        .cons      (cons_idx),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .smp_ready (smp_ready),
        .mw_valid  (mw_valid),
        .mw_req    (mw_req),
        .mw_ready  (mw_ready),
        .prod_idx  (prod_idx),
        .wr_done   (wr_done)
    );

    cap_ring_period period_i (
        .clk       (clk),
        .rst       (rst),
        .srst      (srst_w),
        .wr_done   (wr_done),
        .pcfg      (pcfg),
        .irq_we    (irq_we),
        .irq_addr  (irq_addr),
        .irq_wdata (irq_wdata),
        .irq_rdata (irq_rdata),
        .irq_out   (irq_out)
    );

    assign mw_addr = mw_req.addr;
    assign mw_data = mw_req.data;

endmodule

// File: rtl/cap_ring_writer_chk.sv
module cap_ring_writer_chk #(
    parameter int unsigned IDX_W = 21
) (
    input logic             clk,
    input logic             rst,
    input logic             srst_w,
    input logic             cfg_en,
    input logic [IDX_W-1:0] prod_idx,
    input logic [IDX_W-1:0] cons_idx,
    input logic [IDX_W-1:0] idx_mask,
    input logic             smp_ready,
    input logic             mw_valid,
    input logic             mw_ready,
    input logic [31:0]      mw_addr,
    input logic [31:0]      mw_data
);

    // R2: producer steps one word, folded by the mask, on each memory accept
    a_r2_index_step: assert property (@(posedge clk) disable iff (rst)
        (mw_valid && mw_ready && !srst_w)
        |=> prod_idx == (($past(prod_idx) + IDX_W'(4)) & $past(idx_mask)));

    // R3: producer never lands on the consumer offset
    a_r3_no_overrun: assert property (@(posedge clk) disable iff (rst)
        (mw_valid && mw_ready && !srst_w) |=> prod_idx != cons_idx);

    // R4: a stalled request is held
    a_r4_req_hold: assert property (@(posedge clk) disable iff (rst)
        (mw_valid && !mw_ready && !srst_w)
        |=> mw_valid && $stable(mw_addr) && $stable(mw_data));

    // R5: disabled block takes no samples
    a_r5_no_take_disabled: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |-> !smp_ready);

    // R6: soft reset empties the ring and withdraws the request
    a_r6_soft_clear: assert property (@(posedge clk) disable iff (rst)
        srst_w |=> (prod_idx == '0) && (cons_idx == '0) && !mw_valid);

endmodule

bind cap_ring_writer cap_ring_writer_chk #(.IDX_W(IDX_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .srst_w    (srst_w),
    .cfg_en    (cfg_en),
    .prod_idx  (prod_idx),
    .cons_idx  (cons_idx),
    .idx_mask  (idx_mask),
    .smp_ready (smp_ready),
    .mw_valid  (mw_valid),
    .mw_ready  (mw_ready),
    .mw_addr   (mw_addr),
    .mw_data   (mw_data)
);

// File: tb/cap_ring_writer_tb_top.sv
module cap_ring_writer_tb_top;

    localparam logic [31:0] BASE  = 32'h0000_1000;
    localparam int          SIZE  = 32;
    localparam int          SLOTS = SIZE / 4;
    localparam logic [31:0] SBASE = 32'hA500_0000;

    logic        clk;
    logic        rst;
    logic        cfg_we;
    logic [7:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic        irq_we;
    logic [3:0]  irq_addr;
    logic [31:0] irq_wdata;
    logic [31:0] irq_rdata;
    logic        irq_out;
    logic        smp_valid;
    logic [31:0] smp_data;
    logic        smp_ready;
    logic        mw_valid;
    logic [31:0] mw_addr;
    logic [31:0] mw_data;
    logic        mw_ready;

    int          errs;
    int          checks;
    int          bad_addr;
    int          nsamp;
    bit          done;
    logic [31:0] mem [SLOTS];

    cap_ring_writer dut_i (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .irq_we(irq_we), .irq_addr(irq_addr), .irq_wdata(irq_wdata), .irq_rdata(irq_rdata),
        .irq_out(irq_out),
        .smp_valid(smp_valid), .smp_data(smp_data), .smp_ready(smp_ready),
        .mw_valid(mw_valid), .mw_addr(mw_addr), .mw_data(mw_data), .mw_ready(mw_ready)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    // memory model
    always @(posedge clk) begin
        if (mw_valid && mw_ready) begin
            if ((mw_addr < BASE) || (mw_addr >= BASE + SIZE) || (mw_addr[1:0] != 2'b00))
                bad_addr <= bad_addr + 1;
            else
                mem[mw_addr[4:2]] <= mw_data;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_wr(input logic [7:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_rd(input logic [7:0] a, output logic [31:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic irq_wr(input logic [3:0] a, input logic [31:0] d);
        irq_we = 1'b1; irq_addr = a; irq_wdata = d;
        @(negedge clk);
        irq_we = 1'b0;
    endtask

    task automatic irq_rd(input logic [3:0] a, output logic [31:0] d);
        irq_addr = a;
        #1;
        d = irq_rdata;
    endtask

    task automatic send_one(input int maxw, output bit ok);
        smp_data  = SBASE + 32'(nsamp);
        smp_valid = 1'b1;
        ok = 1'b0;
        for (int w = 0; w < maxw; w++) begin
            if (smp_ready) begin
                @(negedge clk);
                ok = 1'b1;
                nsamp++;
                break;
            end
            @(negedge clk);
        end
        smp_valid = 1'b0;
    endtask

    task automatic drain();
        for (int g = 0; g < 50; g++) begin
            if (!mw_valid) break;
            @(negedge clk);
        end
    endtask

    task automatic send_n(input int n, input string tag);
        bit ok;
        for (int i = 0; i < n; i++) begin
            send_one(40, ok);
            chk(tag, 32'(ok), 32'd1);
        end
        drain();
    endtask

    initial begin
        errs = 0; checks = 0; done = 0;
        #(8 * 150000);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] hold_addr;
        logic [31:0] hold_data;
        bit ok;
        bad_addr = 0; nsamp = 0;
        rst = 1'b1; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
        irq_we = 0; irq_addr = 0; irq_wdata = 0;
        smp_valid = 0; smp_data = 0; mw_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        cfg_rd(8'h20, rd); chk("R1 prod", rd, 32'd0);
        chk("R1 mw_valid", 32'(mw_valid), 32'd0);
        chk("R1 smp_ready", 32'(smp_ready), 32'd0);
        chk("R1 irq_out", 32'(irq_out), 32'd0);

        // R2/R3 fill until one slot short of consumer
        cfg_wr(8'h18, BASE);
        cfg_wr(8'h1C, 32'(SIZE));
        cfg_wr(8'h24, 32'd0);
        cfg_wr(8'h14, 32'd1);
        send_n(SLOTS - 1, "R2 accept");
        for (int k = 0; k < SLOTS - 1; k++) chk("R2 slot data", mem[k], SBASE + 32'(k));
        cfg_rd(8'h20, rd); chk("R3 prod at stall", rd, 32'd28);
        send_one(20, ok);
        chk("R3 stalled", 32'(ok), 32'd0);
        chk("R3 ready low", 32'(smp_ready), 32'd0);

        // R2/R3 wrap after consumer advances
        cfg_wr(8'h24, 32'd16);
        send_n(4, "R3 resume");
        chk("R2 wrap slot7", mem[7], SBASE + 32'd7);
        chk("R2 wrap slot0", mem[0], SBASE + 32'd8);
        chk("R2 wrap slot2", mem[2], SBASE + 32'd10);
        cfg_rd(8'h20, rd); chk("R2 prod wrapped", rd, 32'd12);
        send_one(20, ok);
        chk("R3 stall after wrap", 32'(ok), 32'd0);
        chk("R2 address range", 32'(bad_addr), 32'd0);

        // R6 soft reset withdraws pending write
        cfg_wr(8'h24, 32'd8);
        mw_ready = 1'b0;
        send_one(20, ok);
        chk("R6 pending accepted", 32'(mw_valid), 32'd1);
        cfg_wr(8'h2C, 32'd1);
        chk("R6 request withdrawn", 32'(mw_valid), 32'd0);
        mw_ready = 1'b1;
        cfg_rd(8'h20, rd); chk("R6 prod cleared", rd, 32'd0);
        cfg_rd(8'h24, rd); chk("R6 cons cleared", rd, 32'd0);

        // R7 period with interrupt enable clear
        cfg_wr(8'h30, 32'd2);
        cfg_wr(8'h4C, 32'h0000_0300);
        irq_wr(4'h8, 32'd1);
        send_n(6, "R7 ie0 send");
        irq_rd(4'hC, rd); chk("R7 ie0 no pend", rd, 32'd0);
        chk("R7 ie0 irq low", 32'(irq_out), 32'd0);

        // R7 period of 3 frames x 2 channels
        cfg_wr(8'h2C, 32'd1);
        cfg_wr(8'h4C, 32'h0000_0301);
        send_n(5, "R7 send5");
        irq_rd(4'hC, rd); chk("R7 not yet at 5 words", rd, 32'd0);
        send_n(1, "R7 send6");
        irq_rd(4'hC, rd); chk("R7 pend at 6 words", rd, 32'd1);
        chk("R9 irq high", 32'(irq_out), 32'd1);

        // R9 masking
        irq_wr(4'h8, 32'd0);
        chk("R9 masked irq", 32'(irq_out), 32'd0);
        irq_rd(4'hC, rd); chk("R9 pend kept", rd, 32'd1);
        irq_wr(4'h8, 32'd1);
        chk("R9 unmasked irq", 32'(irq_out), 32'd1);

        // R8 write-one-to-clear
        irq_wr(4'hC, 32'd1);
        irq_rd(4'hC, rd); chk("R8 cleared", rd, 32'd0);
        chk("R8 irq low", 32'(irq_out), 32'd0);

        // R7 repeated period
        cfg_wr(8'h24, 32'd24);
        send_n(5, "R7 repeat send");
        irq_rd(4'hC, rd); chk("R7 repeat not yet", rd, 32'd0);
        send_n(1, "R7 repeat last");
        irq_rd(4'hC, rd); chk("R7 repeat pend", rd, 32'd1);
        cfg_rd(8'h20, rd); chk("R2 prod after repeat", rd, 32'd16);
        irq_wr(4'hC, 32'd1);

        // R7 channel count 0 behaves as 1, period 2
        cfg_wr(8'h2C, 32'd1);
        cfg_wr(8'h30, 32'd0);
        cfg_wr(8'h4C, 32'h0000_0201);
        send_n(1, "R7 ch0 send1");
        irq_rd(4'hC, rd); chk("R7 ch0 after 1", rd, 32'd0);
        send_n(1, "R7 ch0 send2");
        irq_rd(4'hC, rd); chk("R7 ch0 after 2", rd, 32'd1);
        irq_wr(4'hC, 32'd1);

        // R5/R4 disable with a stalled write in flight
        cfg_wr(8'h24, 32'd8);
        mw_ready = 1'b0;
        send_one(20, ok);
        chk("R5 accepted before disable", 32'(ok), 32'd1);
        hold_addr = mw_addr; hold_data = mw_data;
        chk("R2 address base+prod", hold_addr, BASE + 32'd8);
        cfg_wr(8'h14, 32'd0);
        repeat (3) @(negedge clk);
        chk("R4 valid held", 32'(mw_valid), 32'd1);
        chk("R4 addr held", mw_addr, hold_addr);
        chk("R4 data held", mw_data, hold_data);
        cfg_rd(8'h20, rd); chk("R5 prod before completion", rd, 32'd8);
        mw_ready = 1'b1;
        drain();
        cfg_rd(8'h20, rd); chk("R5 prod after completion", rd, 32'd12);
        chk("R5 data written", mem[2], SBASE + 32'(nsamp - 1));
        send_one(10, ok);
        chk("R5 no accept when disabled", 32'(ok), 32'd0);

        // R10 readback and read-only producer
        cfg_wr(8'h20, 32'h0000_1234);
        cfg_rd(8'h20, rd); chk("R10 prod ignores write", rd, 32'd12);
        cfg_rd(8'h18, rd); chk("R10 base", rd, BASE);
        cfg_rd(8'h1C, rd); chk("R10 size", rd, 32'(SIZE));
        cfg_rd(8'h24, rd); chk("R10 cons", rd, 32'd8);
        cfg_rd(8'h14, rd); chk("R10 enable", rd, 32'd0);
        cfg_rd(8'h4C, rd); chk("R10 period", rd, 32'h0000_0201);
        cfg_rd(8'h30, rd); chk("R10 chan", rd, 32'd0);
        chk("R2 address range final", 32'(bad_addr), 32'd0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule